// File: doc/BRIEF.md
# Error-Feedback Dithered PWM Generator

The block turns a fine-grained duty command into a constant-frequency pulse-width modulated line. It uses a tick counter much coarser than the command's resolution. Every period is 64 clock ticks long. The integer part of the duty command sets the number of high ticks in a period. The fractional part, in sixteenths of a tick, goes into a small error accumulator once per period. When the accumulator overflows, the current pulse gets one extra tick. The truncation error is therefore shaped like the output of a first-order sigma-delta loop. The average duty resolves 1024 levels, even though any single period resolves only 64.

A sampling front end presents a new duty word with a one-cycle strobe, usually far less often than once per period. The block keeps the most recent word. That word takes effect only at the next period boundary, so a pulse in progress is never cut short or stretched. A second output marks the first tick of every period, so downstream logic can align to the switching frame.

Top module: `dither_pwm`

## Requirements
- R1: While reset is asserted, and in the first clock after it is released, `pwm_o` and `period_start_o` are low. The error accumulator starts from zero, so the first periods follow the model with an accumulator value of 0.
- R2: `period_start_o` is high for exactly one cycle, once every 64 cycles.
- R3: In each period the high time is a single run of ticks. The run starts in the cycle where `period_start_o` is high, and it is the integer part or the integer part plus one tick.
- R4: The duty word is `duty_in[10:4]` integer ticks plus `duty_in[3:0]` sixteenths. At each period load, the sum of the 4-bit accumulator and the fraction is formed. The low 4 bits of that sum become the new accumulator value. The carry out of that sum adds one tick to the period being loaded.
- R5: With a constant duty word over 16 consecutive periods, the total high time is 16 × integer + fraction ticks.
- R6: A strobed word is stored at the strobe. It first governs the period that starts after the current one ends. The pulse in progress keeps its width.
- R7: A duty of 0 keeps `pwm_o` low for the whole period, whatever the accumulator holds.
- R8: A duty of 1024 (full scale) keeps `pwm_o` high for all 64 ticks. The line does not drop low at the boundary between two full-scale periods.
- R9: Duty words above 1024 are clamped to 1024 when they are stored.
- R10: Changes on `duty_in` while `duty_stb` is low have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Tick clock |
| rst_n | input | 1 | Active-low synchronous reset |
| duty_in | input | 11 | Duty command: integer ticks in bits 10:4, sixteenths of a tick in bits 3:0 |
| duty_stb | input | 1 | One-cycle strobe that stores `duty_in` |
| pwm_o | output | 1 | Modulated output line |
| period_start_o | output | 1 | High in the first tick of each period |

## Verification
The assertions check on every cycle that the following hold:
- The stored width and the accumulator change only at a period boundary.
- An extra tick appears exactly when the accumulator wraps.
- The stored width and duty never exceed full scale.
- The pulse rises only at a period start.
- Zero and full-scale widths force the line low and high.
- The start marker never lasts two cycles.

Only the bench's scenarios can show the other properties:
- The exact sequence of widths for a given fraction.
- The 16-period totals.
- The one-period delay of a strobed word when it arrives mid-pulse.
- Clamping of out-of-range words.
- The fact that unstrobed changes on `duty_in` leave the output alone.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;
    // Default geometry: 2**TICK_W ticks per period, FRAC_W fractional bits
    parameter int unsigned DEF_TICK_W = 6;
    parameter int unsigned DEF_FRAC_W = 4;
endpackage

// File: rtl/dpwm_timebase.sv
module dpwm_timebase #(
    parameter int unsigned TICK_W = dpwm_pkg::DEF_TICK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [TICK_W-1:0] cnt_o,
    output logic              wrap_o
);
    typedef struct packed {
        logic [TICK_W-1:0] cnt;
    } tb_state_t;

    tb_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{cnt: '1};
        else        st_q <= st_d;
    end

    assign cnt_o  = st_q.cnt;
    assign wrap_o = &st_q.cnt;

    // R2
    period_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> (cnt_o == '0));
    // R2
    tick_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap_o |=> (cnt_o == $past(cnt_o) + 1'b1));
endmodule

// File: rtl/dpwm_frac_loop.sv
module dpwm_frac_loop #(
    parameter int unsigned TICK_W = dpwm_pkg::DEF_TICK_W,
    parameter int unsigned FRAC_W = dpwm_pkg::DEF_FRAC_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [TICK_W+FRAC_W:0]   duty_in,
    input  logic                     duty_stb,
    input  logic                     wrap_i,
    output logic [TICK_W:0]          width_o
);
    localparam int unsigned DUTY_W = TICK_W + FRAC_W + 1;
    localparam int unsigned WID_W  = TICK_W + 1;
    localparam int unsigned PERIOD = 1 << TICK_W;
    localparam logic [DUTY_W-1:0] FULL_CODE = {1'b1, {(DUTY_W-1){1'b0}}};

    typedef struct packed {
        logic [DUTY_W-1:0] pend;
        logic [FRAC_W-1:0] acc;
        logic [WID_W-1:0]  width;
    } fl_state_t;

    fl_state_t st_d, st_q;

    logic [DUTY_W-1:0] sat_v;
    logic [WID_W-1:0]  int_part;
    logic [FRAC_W-1:0] frac_part;
    logic [FRAC_W:0]   err_sum;

    assign int_part  = st_q.pend[DUTY_W-1:FRAC_W];
    assign frac_part = st_q.pend[FRAC_W-1:0];
    assign err_sum   = {1'b0, st_q.acc} + {1'b0, frac_part};
    assign sat_v     = (duty_in > FULL_CODE) ? FULL_CODE : duty_in;

    always_comb begin
        st_d = st_q;
        if (duty_stb) st_d.pend = sat_v;
        if (wrap_i) begin
            st_d.acc   = err_sum[FRAC_W-1:0];
            st_d.width = int_part + WID_W'(err_sum[FRAC_W]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign width_o = st_q.width;

    // R6
    width_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap_i |=> $stable(st_q.width));
    // R6
    acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap_i |=> $stable(st_q.acc));
    // R4
    carry_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_i |=> ((st_q.width != $past(int_part)) == (st_q.acc < $past(st_q.acc))));
    // R8
    width_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.width <= WID_W'(PERIOD));
    // R9
    pend_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pend <= FULL_CODE);
endmodule

// File: rtl/dpwm_out_stage.sv
module dpwm_out_stage #(
    parameter int unsigned TICK_W = dpwm_pkg::DEF_TICK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TICK_W-1:0] cnt_i,
    input  logic [TICK_W:0]   width_i,
    output logic              pwm_o,
    output logic              start_o
);
    localparam int unsigned WID_W  = TICK_W + 1;
    localparam int unsigned PERIOD = 1 << TICK_W;

    typedef struct packed {
        logic pwm;
        logic start;
    } os_state_t;

    os_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pwm   = ({1'b0, cnt_i} < width_i);
        st_d.start = (cnt_i == '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pwm_o   = st_q.pwm;
    assign start_o = st_q.start;

    // R7
    zero_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (width_i == '0) |=> !st_q.pwm);
    // R8
    full_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (width_i == WID_W'(PERIOD)) |=> st_q.pwm);
    // R3
    rise_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.pwm) |-> st_q.start);
    // R2
    start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.start |=> !st_q.start);
endmodule

// File: rtl/dither_pwm.sv
module dither_pwm #(
    parameter int unsigned TICK_W = dpwm_pkg::DEF_TICK_W,
    parameter int unsigned FRAC_W = dpwm_pkg::DEF_FRAC_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [TICK_W+FRAC_W:0] duty_in,
    input  logic                   duty_stb,
    output logic                   pwm_o,
    output logic                   period_start_o
);
    logic [TICK_W-1:0] tick_cnt;
    logic              tick_wrap;
    logic [TICK_W:0]   pulse_w;

    dpwm_timebase #(.TICK_W(TICK_W)) u_timebase (
        .clk    (clk),
        .rst_n  (rst_n),
        .cnt_o  (tick_cnt),
        .wrap_o (tick_wrap)
    );

    dpwm_frac_loop #(.TICK_W(TICK_W), .FRAC_W(FRAC_W)) u_frac_loop (
        .clk      (clk),
        .rst_n    (rst_n),
        .duty_in  (duty_in),
        .duty_stb (duty_stb),
        .wrap_i   (tick_wrap),
        .width_o  (pulse_w)
    );

    dpwm_out_stage #(.TICK_W(TICK_W)) u_out_stage (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt_i   (tick_cnt),
        .width_i (pulse_w),
        .pwm_o   (pwm_o),
        .start_o (period_start_o)
    );
endmodule

// File: tb/dither_pwm_test.sv
module dither_pwm_test;
    localparam int PER  = 64;
    localparam int FULL = 1024;

    typedef struct {
        int    width;
        string req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] duty_in = '0;
    logic        duty_stb = 1'b0;
    logic        pwm_o, period_start_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    exp_t exp_q[$];
    int   meas[$];
    int   seg_first[$], seg_n[$], seg_exp[$];

    int acc_m  = 0;
    int duty_m = 0;
    int pidx   = 0;

    always #2 clk = ~clk;

    dither_pwm uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .duty_in        (duty_in),
        .duty_stb       (duty_stb),
        .pwm_o          (pwm_o),
        .period_start_o (period_start_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int sat(input int v);
        return (v > FULL) ? FULL : v;
    endfunction

    // Wait for the next period start, push its expected width, optionally strobe
    task automatic run_period(input bit do_stb, input int code, input int offset, input string req);
        int ip, fp, s, c;
        @(negedge clk);
        while (!period_start_o) @(negedge clk);
        ip = duty_m >> 4;
        fp = duty_m & 15;
        s  = acc_m + fp;
        c  = (s >= 16) ? 1 : 0;
        acc_m = s % 16;
        exp_q.push_back('{width: ip + c, req: req});
        pidx++;
        if (do_stb) begin
            repeat (offset) @(negedge clk);
            duty_in  = 11'(code);
            duty_stb = 1'b1;
            @(negedge clk);
            duty_stb = 1'b0;
            duty_m   = sat(code);
        end
    endtask

    task automatic run_const(input int n, input string req, input bit record_sum);
        int first;
        first = pidx;
        for (int k = 0; k < n; k++) run_period(1'b0, 0, 0, req);
        if (record_sum) begin
            seg_first.push_back(first);
            seg_n.push_back(n);
            seg_exp.push_back(16 * (duty_m >> 4) + (duty_m & 15));
        end
    endtask

    // Monitor: measures every period and compares against the scoreboard
    initial begin
        int   hi;
        bit   shape_ok, extra_start;
        exp_t e;
        @(negedge clk);
        while (!(rst_n && period_start_o)) @(negedge clk);
        forever begin
            hi = 0;
            shape_ok = 1'b1;
            extra_start = 1'b0;
            for (int i = 0; i < PER; i++) begin
                if (i > 0) begin
                    @(negedge clk);
                    if (period_start_o) extra_start = 1'b1;
                end
                if (pwm_o) begin
                    if (hi != i) shape_ok = 1'b0;
                    hi++;
                end
            end
            meas.push_back(hi);
            chk(!extra_start, "R2", 1, 0);
            chk(shape_ok, "R3", 0, 1);
            if (exp_q.size() == 0) begin
                chk(1'b0, "R3", hi, -1);
            end else begin
                e = exp_q.pop_front();
                chk(hi == e.width, e.req, hi, e.width);
            end
            @(negedge clk);
            chk(period_start_o == 1'b1, "R2", int'(period_start_o), 1);
        end
    end

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual 0 expected 1");
            summary();
            $finish;
        end
    end

    initial begin
        int tot;
        // R1: reset state
        repeat (5) begin
            @(negedge clk);
            chk(pwm_o == 1'b0 && period_start_o == 1'b0, "R1", int'(pwm_o), 0);
        end
        rst_n = 1'b1;
        @(negedge clk);
        chk(pwm_o == 1'b0 && period_start_o == 1'b0, "R1", int'(period_start_o), 0);

        run_period(1'b0, 0, 0, "R1");
        run_period(1'b0, 0, 0, "R7");
        // 5 + 3/16, strobed in the start tick
        run_period(1'b1, 83, 0, "R6");
        run_const(16, "R4", 1'b1);
        // 30 + 8/16, strobed mid-pulse: current period keeps its width
        run_period(1'b1, 488, 20, "R6");
        run_const(16, "R3", 1'b1);
        // 10 + 15/16
        run_period(1'b1, 175, 5, "R6");
        run_const(16, "R4", 1'b1);
        // full scale
        run_period(1'b1, 1024, 40, "R6");
        run_const(3, "R8", 1'b0);
        // above full scale clamps
        run_period(1'b1, 1500, 0, "R8");
        run_const(2, "R9", 1'b0);
        run_period(1'b1, 2047, 30, "R9");
        run_const(2, "R9", 1'b0);
        // 63 + 15/16
        run_period(1'b1, 1023, 10, "R9");
        run_const(16, "R4", 1'b1);
        // zero with a nonzero accumulator
        run_period(1'b1, 0, 3, "R4");
        run_const(3, "R7", 1'b0);
        // unstrobed changes are ignored
        duty_in = 11'd700;
        run_const(3, "R10", 1'b0);
        duty_in = 11'd1024;
        run_const(2, "R10", 1'b0);
        // one sixteenth
        run_period(1'b1, 1, 50, "R10");
        run_const(16, "R5", 1'b1);
        run_period(1'b0, 0, 0, "R5");

        repeat (PER + 8) @(negedge clk);

        // R5: 16-period totals
        for (int s = 0; s < seg_first.size(); s++) begin
            tot = 0;
            if (meas.size() >= seg_first[s] + seg_n[s]) begin
                for (int k = 0; k < seg_n[s]; k++) tot += meas[seg_first[s] + k];
            end else begin
                tot = -1;
            end
            chk(tot == seg_exp[s], "R5", tot, seg_exp[s]);
        end

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule